// File: doc/BRIEF.md
# Halfword-to-Word DMA Gap Packer

This bridge sits between a 16-bit bus-master device and a 32-bit shared memory. The device sees a flat 64 KB window addressed in bytes, with halfword granularity. The host sees the same data spread over a 128 KB region that starts on a 128 KB boundary. The bridge accepts two kinds of device access, a lone halfword or a run of eight halfwords. It turns them into 32-bit memory writes, or turns 32-bit memory reads back into halfwords.

The two access kinds land in memory differently. A lone halfword gets a 32-bit slot of its own: the data sits in the low two bytes and the high two bytes are left alone. Host software uses this form for control structures. An eight-halfword run is packed two halfwords per word into four consecutive words. That makes 16 bytes of data, followed by a 16-byte hole that the bridge never writes. Each 16-byte device chunk therefore takes a 32-byte stride in memory.

Software supplies the window start in `cfg_base_ptr` as the physical address shifted left by three. It opens the bridge with `cfg_dma_en`. Device addresses beyond the 64 KB window produce a single-cycle error pulse and no memory traffic.

Top module: `hwgp_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_req`, `dev_ready`, `dev_rvalid` and `dev_err` are all low.
- R2: While `cfg_dma_en` is low, `dev_ready` and `mem_req` stay low. Dropping `cfg_dma_en` in the middle of a transfer abandons the words not yet issued. From the next cycle on, no memory request is made, and the bridge afterwards accepts a fresh request normally.
- R3: The memory window start is `cfg_base_ptr >> 3` with its low 17 bits forced to zero.
- R4: A lone halfword write (`dev_we`=1, `dev_burst`=0) to device byte address o writes one word at memory byte address base + 2*(o with bit 0 cleared). The word carries the halfword in bits [15:0], and `mem_be` is 4'b0011.
- R5: A lone halfword read reads the word at base + 2*(o with bit 0 cleared). Bits [15:0] of that word come back on `dev_rdata` with `dev_rvalid` high for exactly one cycle.
- R6: An eight-halfword write (`dev_burst`=1) uses chunk address c, which is o with its low 4 bits cleared. It produces four writes at base + 2c + 4k for k = 0..3, in ascending order. Word k holds halfword 2k in bits [15:0] and halfword 2k+1 in bits [31:16], and `mem_be` is 4'b1111.
- R7: An eight-halfword access never touches memory bytes base + 2c + 16 through base + 2c + 31.
- R8: An eight-halfword read issues four reads in ascending address order. It returns eight halfwords on `dev_rdata`, each flagged by `dev_rvalid`: for each word the bits [15:0] come first, then bits [31:16].
- R9: A request whose `dev_addr` has any bit above bit 15 set gets no `dev_ready` and causes no memory request. It raises `dev_err` for exactly one cycle, and the bridge waits for `dev_req` to drop before taking new requests.
- R10: Once raised, `mem_req` holds together with an unchanged `mem_addr`, `mem_we`, `mem_be` and `mem_wdata` until `mem_ack`. Each acknowledged write is made exactly once, whatever the memory latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dma_en | input | 1 | Opens the bridge to device requests; low aborts transfers |
| cfg_base_ptr | input | 32 | Window start, physical address shifted left by 3 |
| dev_req | input | 1 | Device presents a halfword beat or read request |
| dev_we | input | 1 | 1 = device writes, 0 = device reads |
| dev_burst | input | 1 | 1 = eight-halfword run, 0 = lone halfword |
| dev_addr | input | 24 | Device byte address, held for the whole transfer |
| dev_wdata | input | 16 | Write halfword of the current beat |
| dev_ready | output | 1 | Beat or request accepted at this clock edge |
| dev_rvalid | output | 1 | `dev_rdata` carries a read halfword |
| dev_rdata | output | 16 | Read halfword |
| dev_err | output | 1 | One-cycle pulse for an out-of-window request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_be | output | 4 | Byte enables of a write |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory finished the access; read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
The hardest situation to reach is `cfg_dma_en` falling in the middle of an eight-halfword write, after one word has gone out and while the next is only half assembled. The bench walks the device beats one at a time and watches for the first memory write to complete. It accepts a third beat and then drops the enable at the following falling edge. The memory write count and the request activity then show that no later word was issued, and a fresh lone write afterwards shows the bridge is back in its idle state. A second hard case is a memory that stalls several cycles before acknowledging. The bench model has a settable latency, and a monitor flags any change of address while a request is waiting.

// File: rtl/hwgp_pkg.sv
// Shared types for the halfword-to-word gap packer.
package hwgp_pkg;
    // Transfer sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a device request
        ST_WGATH,  // collecting write halfwords of a run
        ST_MEMW,   // memory write outstanding
        ST_MEMR,   // memory read outstanding
        ST_RLO,    // returning low halfword of the read word
        ST_RHI,    // returning high halfword of the read word
        ST_EHOLD   // out-of-window request, waiting for it to drop
    } hwgp_state_e;
endpackage

// File: rtl/hwgp_addr_map.sv
// Address mapper: checks the device window and turns the latched device
// offset into a memory byte address.
// Assumes: the memory window is 2^(WIN_AW+1) bytes and aligned to its size;
// lone halfwords map to base + 2*offset; runs map each 2^CHUNK_LSB-byte
// chunk to a stride of twice that size.
module hwgp_addr_map #(
    parameter int DEV_AW    = 24,
    parameter int WIN_AW    = 16,
    parameter int MEM_AW    = 32,
    parameter int PTR_SHIFT = 3,
    parameter int CHUNK_LSB = 4,
    parameter int WIDX_W    = 2
) (
    input  logic [MEM_AW-1:0] cfg_base_ptr,
    input  logic [DEV_AW-1:0] dev_addr,
    input  logic [WIN_AW-1:0] lat_off,
    input  logic              lat_burst,
    input  logic [WIDX_W-1:0] word_idx,
    output logic              in_window,
    output logic [MEM_AW-1:0] mem_addr
);
    localparam int MAP_SPAN = WIN_AW + 1;

    logic [MEM_AW-1:0] base_b;
    logic [MEM_AW-1:0] off_b;

    // Range check on the live request address.
    always_comb in_window = (dev_addr[DEV_AW-1:WIN_AW] == '0);

    // Window base rounded to its size plus the gapped offset.
    always_comb begin
        base_b = cfg_base_ptr >> PTR_SHIFT;
        base_b[MAP_SPAN-1:0] = '0;
        if (lat_burst) begin
            off_b = MEM_AW'({lat_off[WIN_AW-1:CHUNK_LSB], {(CHUNK_LSB+1){1'b0}}})
                  + MEM_AW'({word_idx, 2'b00});
        end else begin
            off_b = MEM_AW'({lat_off[WIN_AW-1:1], 2'b00});
        end
        mem_addr = base_b + off_b;
    end
endmodule

// File: rtl/hwgp_lanes.sv
// Lane packer: assembles halfwords into the write word and splits the
// captured read word back into halfwords.
// Assumes: one strobe at a time from the sequencer; the halfword is half the word.
module hwgp_lanes #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_single,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic          cap_rd,
    input  logic          rd_hi_sel,
    input  logic [HW-1:0] dev_wdata,
    input  logic [2*HW-1:0] mem_rdata,
    output logic [2*HW-1:0] wword,
    output logic [HW-1:0] rhalf
);
    logic [2*HW-1:0] rbuf;

    // Write word assembly and read word capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wword <= '0;
            rbuf  <= '0;
        end else begin
            if (ld_single) wword <= {{HW{1'b0}}, dev_wdata};
            if (ld_lo)     wword[HW-1:0] <= dev_wdata;
            if (ld_hi)     wword[2*HW-1:HW] <= dev_wdata;
            if (cap_rd)    rbuf <= mem_rdata;
        end
    end

    // Halfword selection for the device read lane.
    always_comb rhalf = rd_hi_sel ? rbuf[2*HW-1:HW] : rbuf[HW-1:0];
endmodule

// File: rtl/hwgp_ctrl.sv
// Transfer sequencer: accepts device beats, issues memory accesses and
// returns read halfwords. Clearing the enable returns it to idle.
// Assumes: the device holds address and kind for the whole transfer and
// keeps dev_req high until the last beat of a run is accepted.
module hwgp_ctrl
    import hwgp_pkg::*;
#(
    parameter int WIN_AW      = 16,
    parameter int BURST_WORDS = 4,
    parameter int WIDX_W      = 2,
    parameter int BE_W        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dma_en,
    input  logic              dev_req,
    input  logic              dev_we,
    input  logic              dev_burst,
    input  logic [WIN_AW-1:0] dev_off,
    input  logic              in_window,
    input  logic              mem_ack,
    output logic              dev_ready,
    output logic              dev_rvalid,
    output logic              dev_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [BE_W-1:0]   mem_be,
    output logic [WIN_AW-1:0] lat_off,
    output logic              lat_burst,
    output logic [WIDX_W-1:0] word_idx,
    output logic              ld_single,
    output logic              ld_lo,
    output logic              ld_hi,
    output logic              cap_rd,
    output logic              rd_hi_sel
);
    localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(BURST_WORDS - 1);
    localparam logic [BE_W-1:0]   BE_ALL   = '1;
    localparam logic [BE_W-1:0]   BE_LOW   = BE_W'((1 << (BE_W / 2)) - 1);

    hwgp_state_e state;
    logic        half_q;
    logic        err_q;

    // Handshake and strobe decode from the current state.
    always_comb begin
        dev_ready  = 1'b0;
        dev_rvalid = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_be     = '0;
        ld_single  = 1'b0;
        ld_lo      = 1'b0;
        ld_hi      = 1'b0;
        cap_rd     = 1'b0;
        rd_hi_sel  = 1'b0;
        case (state)
            ST_IDLE: if (cfg_dma_en && dev_req && in_window) begin
                dev_ready = 1'b1;
                if (dev_we) begin
                    ld_lo     = dev_burst;
                    ld_single = !dev_burst;
                end
            end
            ST_WGATH: if (cfg_dma_en && dev_req) begin
                dev_ready = 1'b1;
                ld_hi     = half_q;
                ld_lo     = !half_q;
            end
            ST_MEMW: begin
                mem_req = cfg_dma_en;
                mem_we  = 1'b1;
                mem_be  = lat_burst ? BE_ALL : BE_LOW;
            end
            ST_MEMR: begin
                mem_req = cfg_dma_en;
                cap_rd  = cfg_dma_en && mem_ack;
            end
            ST_RLO: dev_rvalid = cfg_dma_en;
            ST_RHI: begin
                dev_rvalid = cfg_dma_en;
                rd_hi_sel  = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb dev_err = err_q;

    // State, word counter, beat parity and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            half_q    <= 1'b0;
            err_q     <= 1'b0;
            word_idx  <= '0;
            lat_off   <= '0;
            lat_burst <= 1'b0;
        end else if (!cfg_dma_en) begin
            state    <= ST_IDLE;
            half_q   <= 1'b0;
            err_q    <= 1'b0;
            word_idx <= '0;
        end else begin
            err_q <= 1'b0;
            case (state)
                ST_IDLE: if (dev_req) begin
                    if (!in_window) begin
                        state <= ST_EHOLD;
                        err_q <= 1'b1;
                    end else begin
                        lat_off   <= dev_off;
                        lat_burst <= dev_burst;
                        word_idx  <= '0;
                        if (!dev_we)        state <= ST_MEMR;
                        else if (dev_burst) begin
                            half_q <= 1'b1;
                            state  <= ST_WGATH;
                        end else            state <= ST_MEMW;
                    end
                end
                ST_WGATH: if (dev_req) begin
                    half_q <= !half_q;
                    if (half_q) state <= ST_MEMW;
                end
                ST_MEMW: if (mem_ack) begin
                    if (!lat_burst || word_idx == LAST_IDX) state <= ST_IDLE;
                    else begin
                        word_idx <= word_idx + 1'b1;
                        state    <= ST_WGATH;
                    end
                end
                ST_MEMR: if (mem_ack) state <= ST_RLO;
                ST_RLO:  state <= lat_burst ? ST_RHI : ST_IDLE;
                ST_RHI: begin
                    if (word_idx == LAST_IDX) state <= ST_IDLE;
                    else begin
                        word_idx <= word_idx + 1'b1;
                        state    <= ST_MEMR;
                    end
                end
                ST_EHOLD: if (!dev_req) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: the error indication lasts one cycle only.
    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_err |=> !dev_err);
    // R9: an error cycle carries neither memory traffic nor acceptance.
    assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_err |-> (!mem_req && !dev_ready));
    // R2: after a disabled cycle nothing is requested or returned.
    assert_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dma_en |=> (!mem_req && !dev_rvalid));
    // R10: an unanswered request stays up unless the bridge is disabled.
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req || !cfg_dma_en));
    // R8: a low read halfword of a run is followed by its high halfword.
    assert_rd_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rvalid && lat_burst && !rd_hi_sel) |=> (dev_rvalid || !cfg_dma_en));
endmodule

// File: rtl/hwgp_bridge.sv
// Halfword-to-word DMA gap packer, top level: ties the address mapper,
// lane packer and sequencer together.
// Assumes: the memory answers each request with a one-cycle mem_ack and
// read data valid in that cycle; cfg_base_ptr is static during transfers.
module hwgp_bridge #(
    parameter int DEV_AW    = 24,
    parameter int WIN_AW    = 16,
    parameter int MEM_AW    = 32,
    parameter int HW        = 16,
    parameter int BURST_HW  = 8,
    parameter int PTR_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dma_en,
    input  logic [MEM_AW-1:0] cfg_base_ptr,
    input  logic              dev_req,
    input  logic              dev_we,
    input  logic              dev_burst,
    input  logic [DEV_AW-1:0] dev_addr,
    input  logic [HW-1:0]     dev_wdata,
    output logic              dev_ready,
    output logic              dev_rvalid,
    output logic [HW-1:0]     dev_rdata,
    output logic              dev_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [2*HW/8-1:0] mem_be,
    output logic [2*HW-1:0]   mem_wdata,
    input  logic              mem_ack,
    input  logic [2*HW-1:0]   mem_rdata
);
    localparam int BURST_WORDS = BURST_HW / 2;
    localparam int WIDX_W      = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;
    localparam int CHUNK_LSB   = $clog2(BURST_HW * HW / 8);
    localparam int BE_W        = 2 * HW / 8;

    logic              in_window;
    logic [WIN_AW-1:0] lat_off;
    logic              lat_burst;
    logic [WIDX_W-1:0] word_idx;
    logic              ld_single, ld_lo, ld_hi, cap_rd, rd_hi_sel;

    hwgp_addr_map #(
        .DEV_AW(DEV_AW), .WIN_AW(WIN_AW), .MEM_AW(MEM_AW),
        .PTR_SHIFT(PTR_SHIFT), .CHUNK_LSB(CHUNK_LSB), .WIDX_W(WIDX_W)
    ) map_i (
        .cfg_base_ptr(cfg_base_ptr), .dev_addr(dev_addr), .lat_off(lat_off),
        .lat_burst(lat_burst), .word_idx(word_idx),
        .in_window(in_window), .mem_addr(mem_addr)
    );

    hwgp_lanes #(.HW(HW)) lanes_i (
        .clk(clk), .rst_n(rst_n), .ld_single(ld_single), .ld_lo(ld_lo),
        .ld_hi(ld_hi), .cap_rd(cap_rd), .rd_hi_sel(rd_hi_sel),
        .dev_wdata(dev_wdata), .mem_rdata(mem_rdata),
        .wword(mem_wdata), .rhalf(dev_rdata)
    );

    hwgp_ctrl #(
        .WIN_AW(WIN_AW), .BURST_WORDS(BURST_WORDS), .WIDX_W(WIDX_W), .BE_W(BE_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .cfg_dma_en(cfg_dma_en), .dev_req(dev_req),
        .dev_we(dev_we), .dev_burst(dev_burst), .dev_off(dev_addr[WIN_AW-1:0]),
        .in_window(in_window), .mem_ack(mem_ack), .dev_ready(dev_ready),
        .dev_rvalid(dev_rvalid), .dev_err(dev_err), .mem_req(mem_req),
        .mem_we(mem_we), .mem_be(mem_be), .lat_off(lat_off),
        .lat_burst(lat_burst), .word_idx(word_idx), .ld_single(ld_single),
        .ld_lo(ld_lo), .ld_hi(ld_hi), .cap_rd(cap_rd), .rd_hi_sel(rd_hi_sel)
    );

    // R4: every memory access is word aligned.
    assert_word_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
    // R7: run accesses stay in the data half of each 32-byte stride.
    assert_gap_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && lat_burst) |-> (mem_addr[CHUNK_LSB] == 1'b0));
    // R10: a waiting request keeps its address and data.
    assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (!mem_req || ($stable(mem_addr) && $stable(mem_wdata))));
endmodule

// File: tb/hwgp_bridge_tb.sv
// Self-checking bench for the gap packer: table of lone-halfword cases,
// then directed runs, window, enable and latency cases.
module hwgp_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 20000;
    localparam logic [31:0] BASE_A = 32'h0004_0000;
    localparam logic [31:0] BASE_B = 32'h0006_0000;

    // Lone-halfword vectors: {device address, write data}.
    localparam int NVEC = 7;
    localparam logic [39:0] VEC [NVEC] = '{
        {24'h000000, 16'h1234}, {24'h000002, 16'hBEEF}, {24'h000010, 16'h0F0F},
        {24'h000ABC, 16'hA55A}, {24'h007FFE, 16'h8001}, {24'h00FFFE, 16'hFFFF},
        {24'h000101, 16'h3C3C}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_dma_en = 1'b0;
    logic [31:0] cfg_base_ptr = BASE_A << 3;
    logic        dev_req = 1'b0, dev_we = 1'b0, dev_burst = 1'b0;
    logic [23:0] dev_addr = '0;
    logic [15:0] dev_wdata = '0;
    logic        dev_ready, dev_rvalid, dev_err;
    logic [15:0] dev_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;

    // Memory model state and observation counters.
    logic [31:0] mem_model [int];
    int          mem_lat = 0;
    int          wait_cnt = 0;
    int          wr_count = 0;
    int          req_cycles = 0;
    int          err_cycles = 0;
    int          hold_viol = 0;
    logic [31:0] last_addr = '0;
    logic [3:0]  last_be = '0;
    logic        prev_pend = 1'b0;
    logic [31:0] prev_addr = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hwgp_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_dma_en(cfg_dma_en), .cfg_base_ptr(cfg_base_ptr),
        .dev_req(dev_req), .dev_we(dev_we), .dev_burst(dev_burst), .dev_addr(dev_addr),
        .dev_wdata(dev_wdata), .dev_ready(dev_ready), .dev_rvalid(dev_rvalid),
        .dev_rdata(dev_rdata), .dev_err(dev_err), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] peek(input logic [31:0] a);
        if (mem_model.exists(int'(a >> 2))) return mem_model[int'(a >> 2)];
        return 32'h0;
    endfunction

    // Memory with settable latency, plus monitors.
    always @(posedge clk) begin
        if (mem_req) req_cycles++;
        if (dev_err) err_cycles++;
        if (prev_pend && mem_req && mem_addr != prev_addr) hold_viol++;
        prev_pend = mem_req && !mem_ack;
        prev_addr = mem_addr;
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wait_cnt = 0;
        end else if (mem_req && !mem_ack) begin
            if (wait_cnt < mem_lat) wait_cnt++;
            else begin
                wait_cnt = 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    logic [31:0] w;
                    w = peek(mem_addr);
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) w[8*b +: 8] = mem_wdata[8*b +: 8];
                    mem_model[int'(mem_addr >> 2)] = w;
                    wr_count++;
                    last_addr = mem_addr;
                    last_be = mem_be;
                end else mem_rdata <= peek(mem_addr);
            end
        end else mem_ack <= 1'b0;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One device beat: drive at a falling edge, wait for acceptance.
    task automatic beat(input logic we, input logic burst, input logic [23:0] a,
                        input logic [15:0] d);
        int guard = 0;
        dev_req = 1'b1; dev_we = we; dev_burst = burst; dev_addr = a; dev_wdata = d;
        #1;
        while (!dev_ready && guard < 200) begin
            @(negedge clk); #1; guard++;
        end
        @(negedge clk);
    endtask

    task automatic wr_single(input logic [23:0] a, input logic [15:0] d);
        beat(1'b1, 1'b0, a, d);
        dev_req = 1'b0;
        repeat (4 + 2 * mem_lat) @(negedge clk);
    endtask

    task automatic wr_burst(input logic [23:0] a, input logic [15:0] d [8]);
        for (int i = 0; i < 8; i++) beat(1'b1, 1'b1, a, d[i]);
        dev_req = 1'b0;
        repeat (4 + 2 * mem_lat) @(negedge clk);
    endtask

    task automatic rd(input logic [23:0] a, input logic burst, input int n,
                      output logic [15:0] q [8]);
        int got = 0;
        int guard = 0;
        for (int i = 0; i < 8; i++) q[i] = 16'hxxxx;
        beat(1'b0, burst, a, 16'h0);
        dev_req = 1'b0;
        while (got < n && guard < 200) begin
            if (dev_rvalid) begin q[got] = dev_rdata; got++; end
            @(negedge clk); guard++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] q [8];
        logic [15:0] hw [8];
        int w0, r0, e0;

        // R1: outputs quiet in reset and just after.
        repeat (3) @(negedge clk);
        chk("R1 mem_req in reset", 32'(mem_req), 0);
        chk("R1 dev_rvalid in reset", 32'(dev_rvalid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mem_req after reset", 32'(mem_req), 0);
        chk("R1 dev_ready after reset", 32'(dev_ready), 0);
        chk("R1 dev_err after reset", 32'(dev_err), 0);
        cfg_dma_en = 1'b1;

        // R4 and R5: table of lone halfword writes and read-backs.
        for (int v = 0; v < NVEC; v++) begin
            logic [23:0] a;
            logic [15:0] d;
            logic [31:0] exp_a;
            a = VEC[v][39:16];
            d = VEC[v][15:0];
            exp_a = BASE_A + 32'({a[15:1], 1'b0}) * 2;
            mem_model[int'(exp_a >> 2)] = 32'h7777_0000;
            wr_single(a, d);
            chk($sformatf("R4 addr vec%0d", v), last_addr, exp_a);
            chk($sformatf("R4 be vec%0d", v), 32'(last_be), 32'h3);
            chk($sformatf("R4 word vec%0d", v), peek(exp_a), {16'h7777, d});
            rd(a, 1'b0, 1, q);
            chk($sformatf("R5 read vec%0d", v), 32'(q[0]), 32'(d));
        end

        // R6 and R7: run write at 0x0120 with gap words prefilled.
        for (int k = 0; k < 4; k++) mem_model[int'((BASE_A + 32'h250 + 4 * k) >> 2)] = 32'hA5A5_0000 + k;
        for (int i = 0; i < 8; i++) hw[i] = 16'h1100 + 16'(i * 17);
        w0 = wr_count;
        wr_burst(24'h000120, hw);
        chk("R6 run write count", 32'(wr_count - w0), 4);
        chk("R6 run be", 32'(last_be), 32'hF);
        for (int k = 0; k < 4; k++)
            chk($sformatf("R6 run word%0d", k), peek(BASE_A + 32'h240 + 4 * k), {hw[2*k+1], hw[2*k]});
        for (int k = 0; k < 4; k++)
            chk($sformatf("R7 gap word%0d", k), peek(BASE_A + 32'h250 + 4 * k), 32'hA5A5_0000 + k);

        // R8: run read back, halfwords in ascending order.
        rd(24'h000120, 1'b1, 8, q);
        for (int i = 0; i < 8; i++) chk($sformatf("R8 run read hw%0d", i), 32'(q[i]), 32'(hw[i]));
        // R6: low four address bits of a run are ignored.
        rd(24'h00012A, 1'b1, 8, q);
        chk("R6 unaligned run hw0", 32'(q[0]), 32'(hw[0]));
        chk("R6 unaligned run hw7", 32'(q[7]), 32'(hw[7]));

        // R3: base pointer rounding with junk low bits.
        cfg_base_ptr = (BASE_B << 3) | 32'h000A_BCDE;
        wr_single(24'h000040, 16'h5151);
        chk("R3 rounded base", last_addr, BASE_B + 32'h80);
        cfg_base_ptr = BASE_A << 3;

        // R9: out-of-window lone write and run read.
        w0 = wr_count; r0 = req_cycles; e0 = err_cycles;
        dev_req = 1'b1; dev_we = 1'b1; dev_burst = 1'b0; dev_addr = 24'h010000; dev_wdata = 16'h9999;
        for (int c = 0; c < 4; c++) begin
            #1; chk("R9 no ready out of window", 32'(dev_ready), 0);
            @(negedge clk);
        end
        dev_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 one error pulse", 32'(err_cycles - e0), 1);
        chk("R9 no memory request", 32'(req_cycles - r0), 0);
        e0 = err_cycles;
        dev_req = 1'b1; dev_we = 1'b0; dev_burst = 1'b1; dev_addr = 24'h800020;
        repeat (3) @(negedge clk);
        dev_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 read error pulse", 32'(err_cycles - e0), 1);
        chk("R9 nothing written", 32'(wr_count - w0), 0);
        wr_single(24'h000004, 16'h4444);
        chk("R9 recovers", last_addr, BASE_A + 32'h8);

        // R2: disabled bridge refuses a request, then serves it.
        cfg_dma_en = 1'b0;
        r0 = req_cycles;
        dev_req = 1'b1; dev_we = 1'b1; dev_burst = 1'b0; dev_addr = 24'h000020; dev_wdata = 16'h2020;
        for (int c = 0; c < 5; c++) begin
            #1; chk("R2 no ready while disabled", 32'(dev_ready), 0);
            @(negedge clk);
        end
        chk("R2 no request while disabled", 32'(req_cycles - r0), 0);
        cfg_dma_en = 1'b1;
        wr_single(24'h000020, 16'h2020);
        chk("R2 served after enable", peek(BASE_A + 32'h40), 32'h0000_2020);

        // R2: enable dropped in the middle of a run write.
        w0 = wr_count;
        for (int i = 0; i < 3; i++) beat(1'b1, 1'b1, 24'h000200, 16'hD000 + 16'(i));
        cfg_dma_en = 1'b0;
        dev_req = 1'b0;
        @(negedge clk);
        r0 = req_cycles;
        repeat (5) @(negedge clk);
        chk("R2 abort leaves one word", 32'(wr_count - w0), 1);
        chk("R2 abort quiet", 32'(req_cycles - r0), 0);
        cfg_dma_en = 1'b1;
        @(negedge clk);
        wr_single(24'h000300, 16'h3030);
        chk("R2 idle after abort", last_addr, BASE_A + 32'h600);

        // R10: slow memory, each word written once with stable address.
        mem_lat = 3;
        w0 = wr_count;
        for (int i = 0; i < 8; i++) hw[i] = 16'h6000 + 16'(i);
        wr_burst(24'h001000, hw);
        chk("R10 slow write count", 32'(wr_count - w0), 4);
        chk("R10 slow word3", peek(BASE_A + 32'h200C), {hw[7], hw[6]});
        rd(24'h001000, 1'b1, 8, q);
        chk("R10 slow read hw5", 32'(q[5]), 32'(hw[5]));
        chk("R10 address held", 32'(hold_viol), 0);
        mem_lat = 0;

        summary();
        $finish;
    end
endmodule